// File: doc/BRIEF.md
# BCD Operand Screen and Product Selector

This block sits ahead of a four-digit by four-digit packed-BCD multiplier. It takes a multiplicand and a multiplier, each sixteen bits of four BCD digits, and sorts the pair into one of four kinds:

- **Malformed:** a digit is above nine.
- **Zero:** either operand is zero.
- **Unit:** either operand is one.
- **Plain:** none of the above, so the pair must go on to the product cache and the multiplier.

For malformed, zero and unit pairs the block forms the 32-bit answer itself and raises a fault flag, so the slow path can be skipped. For a plain pair it forwards the two operands packed into one word, for use as the cache key.

Operands enter over a valid/ready handshake. The classification comes out as a registered result under a second valid/ready handshake. The result register is one entry deep. A new pair is taken when the register is empty, or in the same cycle that its current content is handed off. While the consumer holds ready low, the result and its valid stay frozen and no new pair is accepted.

The block also holds the last-stage selector. It chooses between the screen's own word, a cached product and a freshly computed product. The choice depends on the registered fault flag and a cache-hit input.

Top module: `bcd_operand_screen`

## Requirements
- R1: If any four-bit digit of either operand has a value above 9, the result is fault=1, kind=2'b11 and decision=32'hDEEFDEEF. This check wins over the zero and unit checks.
- R2: If all digits are valid and either operand is 16'h0000, the result is fault=1, kind=2'b01 and decision=0. This check wins over the unit check.
- R3: If all digits are valid, neither operand is zero and one operand is 16'h0001, the result is fault=1 and kind=2'b10. The decision is the other operand zero-extended into bits 15:0. When both operands are one, the decision is 1.
- R4: Otherwise the result is fault=0 and kind=2'b00, with decision = {multiplicand, multiplier}. The multiplicand sits in bits 31:16.
- R5: final_o equals decision_o when fault_o is 1. When fault_o is 0, final_o equals cached_i if hit_i is 1, and computed_i otherwise.
- R6: A pair is accepted at a rising edge where op_valid_i and op_ready_o are both 1. Its result shows with res_valid_o=1 right after that edge. op_ready_o is 1 exactly when res_valid_o is 0 or res_ready_i is 1, so a hand-off and a new accept can share an edge.
- R7: While res_valid_o=1 and res_ready_i=0, the result stays unchanged and valid, and operands offered on op_valid_i are not taken.
- R8: A synchronous active-high reset clears res_valid_o, fault_o, kind_o and decision_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid_i | input | 1 | Operand pair offered |
| op_ready_o | output | 1 | Block can take a pair this cycle |
| mcand_i | input | 16 | Multiplicand, packed BCD |
| mplier_i | input | 16 | Multiplier, packed BCD |
| res_valid_o | output | 1 | Result register holds a classification |
| res_ready_i | input | 1 | Consumer takes the result this cycle |
| fault_o | output | 1 | Answer formed here; skip cache and multiplier |
| kind_o | output | 2 | 00 plain, 01 zero, 10 unit, 11 malformed |
| decision_o | output | 32 | Screen answer, or packed operands for plain pairs |
| hit_i | input | 1 | Cache found the pair |
| cached_i | input | 32 | Product from the cache |
| computed_i | input | 32 | Product from the multiplier |
| final_o | output | 32 | Selected final product |

## Verification
Two functions of this block can land on the same rising edge: handing off a held result and accepting the next pair. The bench provokes this by holding res_ready_i low after one pair is taken, while a second pair waits on op_valid_i. During the stall it checks that op_ready_o is low and the held word does not move. It then raises ready. The scoreboard must then see both results in order, with the second one's valid never dropping between them. The same stall window is used to drive the selector inputs against a known fault state.

// File: rtl/bcd_screen_pkg.sv
package bcd_screen_pkg;
  localparam int DIG_W = 4;
  localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'b00,
    KIND_ZERO  = 2'b01,
    KIND_UNIT  = 2'b10,
    KIND_BAD   = 2'b11
  } pair_kind_e;
endpackage

// File: rtl/bcd_digit_scan.sv
module bcd_digit_scan
  import bcd_screen_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int OP_W = DIGITS * DIG_W
) (
  input  logic [OP_W-1:0] operand_i,
  output logic            any_bad_o,
  output logic            is_zero_o,
  output logic            is_one_o
);
  logic [DIGITS-1:0] bad_vec;

  genvar gi;
  generate
    for (gi = 0; gi < DIGITS; gi++) begin : g_dig
      assign bad_vec[gi] = operand_i[gi*DIG_W +: DIG_W] > DIG_MAX;
    end
  endgenerate

  assign any_bad_o = |bad_vec;
  assign is_zero_o = (operand_i == '0);
  assign is_one_o  = (operand_i == OP_W'(1));
endmodule

// File: rtl/bcd_pair_classify.sv
module bcd_pair_classify
  import bcd_screen_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter logic [15:0] ERR_TILE = 16'hDEEF,
  localparam int OP_W  = DIGITS * DIG_W,
  localparam int RES_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]  mcand_i,
  input  logic [OP_W-1:0]  mplier_i,
  output pair_kind_e       kind_o,
  output logic             fault_o,
  output logic             bad_o,
  output logic [RES_W-1:0] decision_o
);
  localparam logic [RES_W-1:0] ERR_FULL = {(RES_W/16){ERR_TILE}};

  logic a_bad, a_zero, a_one;
  logic b_bad, b_zero, b_one;

  bcd_digit_scan #(.DIGITS(DIGITS)) u_scan_a (
    .operand_i(mcand_i), .any_bad_o(a_bad), .is_zero_o(a_zero), .is_one_o(a_one)
  );
  bcd_digit_scan #(.DIGITS(DIGITS)) u_scan_b (
    .operand_i(mplier_i), .any_bad_o(b_bad), .is_zero_o(b_zero), .is_one_o(b_one)
  );

  assign bad_o = a_bad | b_bad;

  always_comb begin
    kind_o     = KIND_PLAIN;
    decision_o = {mcand_i, mplier_i};
    if (a_bad || b_bad) begin
      kind_o     = KIND_BAD;
      decision_o = ERR_FULL;
    end else if (a_zero || b_zero) begin
      kind_o     = KIND_ZERO;
      decision_o = '0;
    end else if (a_one) begin
      kind_o     = KIND_UNIT;
      decision_o = {{OP_W{1'b0}}, mplier_i};
    end else if (b_one) begin
      kind_o     = KIND_UNIT;
      decision_o = {{OP_W{1'b0}}, mcand_i};
    end
  end

  assign fault_o = (kind_o != KIND_PLAIN);
endmodule

// File: rtl/bcd_product_select.sv
module bcd_product_select #(
  parameter int RES_W = 32
) (
  input  logic             fault_i,
  input  logic             hit_i,
  input  logic [RES_W-1:0] decision_i,
  input  logic [RES_W-1:0] cached_i,
  input  logic [RES_W-1:0] computed_i,
  output logic [RES_W-1:0] final_o
);
  always_comb begin
    if (fault_i)    final_o = decision_i;
    else if (hit_i) final_o = cached_i;
    else            final_o = computed_i;
  end
endmodule

// File: rtl/bcd_operand_screen.sv
module bcd_operand_screen
  import bcd_screen_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter logic [15:0] ERR_TILE = 16'hDEEF,
  localparam int OP_W  = DIGITS * DIG_W,
  localparam int RES_W = 2 * OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid_i,
  output logic             op_ready_o,
  input  logic [OP_W-1:0]  mcand_i,
  input  logic [OP_W-1:0]  mplier_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic             fault_o,
  output logic [1:0]       kind_o,
  output logic [RES_W-1:0] decision_o,
  input  logic             hit_i,
  input  logic [RES_W-1:0] cached_i,
  input  logic [RES_W-1:0] computed_i,
  output logic [RES_W-1:0] final_o
);
  localparam logic [RES_W-1:0] ERR_FULL = {(RES_W/16){ERR_TILE}};

  pair_kind_e       kind_c;
  logic             fault_c;
  logic             bad_c;
  logic [RES_W-1:0] dec_c;
  logic             take;

  bcd_pair_classify #(.DIGITS(DIGITS), .ERR_TILE(ERR_TILE)) u_cls (
    .mcand_i(mcand_i), .mplier_i(mplier_i), .kind_o(kind_c),
    .fault_o(fault_c), .bad_o(bad_c), .decision_o(dec_c)
  );

  assign op_ready_o = !res_valid_o || res_ready_i;
  assign take       = op_valid_i && op_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      fault_o     <= 1'b0;
      kind_o      <= 2'b00;
      decision_o  <= '0;
    end else if (take) begin
      res_valid_o <= 1'b1;
      fault_o     <= fault_c;
      kind_o      <= kind_c;
      decision_o  <= dec_c;
    end else if (res_ready_i) begin
      res_valid_o <= 1'b0;
    end
  end

  bcd_product_select #(.RES_W(RES_W)) u_sel (
    .fault_i(fault_o), .hit_i(hit_i), .decision_i(decision_o),
    .cached_i(cached_i), .computed_i(computed_i), .final_o(final_o)
  );

  assert_err_word_R1: assert property (@(posedge clk) disable iff (rst)
    (take && bad_c) |=> (fault_o && decision_o == ERR_FULL && kind_o == 2'b11));

  assert_plain_pack_R4: assert property (@(posedge clk) disable iff (rst)
    (take && !fault_c) |=> (!fault_o && decision_o == {$past(mcand_i), $past(mplier_i)}));

  assert_fault_sel_R5: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (final_o == decision_o));

  assert_hit_sel_R5: assert property (@(posedge clk) disable iff (rst)
    (!fault_o && hit_i) |-> (final_o == cached_i));

  assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
    take |=> res_valid_o);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(decision_o) && $stable(fault_o) && $stable(kind_o)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!res_valid_o && !fault_o && kind_o == 2'b00 && decision_o == '0));
endmodule

// File: tb/bcd_operand_screen_bench.sv
`timescale 1ns/1ps
module bcd_operand_screen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [15:0] mcand = '0, mplier = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        fault;
  logic [1:0]  kind;
  logic [31:0] decision;
  logic        hit = 1'b0;
  logic [31:0] cached = '0, computed = '0;
  logic [31:0] final_p;

  int n_vec = 0;
  int n_bad = 0;
  logic [34:0] exp_q[$];

  always #2.5 clk = ~clk;

  bcd_operand_screen u_bcd_operand_screen (
    .clk(clk), .rst(rst), .op_valid_i(op_valid), .op_ready_o(op_ready),
    .mcand_i(mcand), .mplier_i(mplier), .res_valid_o(res_valid),
    .res_ready_i(res_ready), .fault_o(fault), .kind_o(kind),
    .decision_o(decision), .hit_i(hit), .cached_i(cached),
    .computed_i(computed), .final_o(final_p)
  );

  function automatic logic [34:0] model(input logic [15:0] a, input logic [15:0] b);
    logic bad = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (a[i*4 +: 4] > 4'd9 || b[i*4 +: 4] > 4'd9) bad = 1'b1;
    end
    if (bad)                       return {1'b1, 2'b11, 32'hDEEFDEEF};
    if (a == 16'h0 || b == 16'h0)  return {1'b1, 2'b01, 32'h0};
    if (a == 16'h1)                return {1'b1, 2'b10, 16'h0, b};
    if (b == 16'h1)                return {1'b1, 2'b10, 16'h0, a};
    return {1'b0, 2'b00, a, b};
  endfunction

  function automatic string tag(input logic [1:0] k);
    case (k)
      2'b11:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] b);
    @(posedge clk); #1;
    op_valid = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    exp_q.push_back(model(a, b));
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  // monitor: pops on every hand-off (R6, R7 ordering)
  always @(negedge clk) begin
    if (!rst && res_valid && res_ready) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R6: unexpected result got %h expected none", decision);
      end else begin
        logic [34:0] e;
        e = exp_q.pop_front();
        if ({fault, kind, decision} !== e) begin
          n_bad++;
          $display("FAIL %s: got f=%0b k=%0d d=%h expected f=%0b k=%0d d=%h",
                   tag(e[33:32]), fault, kind, decision, e[34], e[33:32], e[31:0]);
        end
      end
    end
  end

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check("R8 valid", {31'b0, res_valid}, 32'h0);
    check("R8 fault", {31'b0, fault}, 32'h0);
    check("R8 kind", {30'b0, kind}, 32'h0);
    check("R8 decision", decision, 32'h0);
    check("R6 ready idle", {31'b0, op_ready}, 32'h1);

    // R4 plain pairs
    send(16'h1234, 16'h5678);
    @(negedge clk);
    check("R6 valid after accept", {31'b0, res_valid}, 32'h1);
    send(16'h9999, 16'h9999);
    send(16'h0002, 16'h0003);
    send(16'h0010, 16'h0100);
    // R1 malformed, with priority
    send(16'h123A, 16'h0005);
    send(16'h0000, 16'hF000);
    send(16'h0001, 16'h00B0);
    send(16'h5555, 16'h9F99);
    // R2 zero, with priority over unit
    send(16'h0000, 16'h1234);
    send(16'h4321, 16'h0000);
    send(16'h0001, 16'h0000);
    send(16'h0000, 16'h0000);
    // R3 unit
    send(16'h0001, 16'h9876);
    send(16'h4567, 16'h0001);
    send(16'h0001, 16'h0001);
    repeat (2) @(posedge clk);

    // R7 stall, then R6 hand-off and accept on one edge
    #1 res_ready = 1'b0;
    send(16'h0001, 16'h0042);
    fork
      send(16'h2468, 16'h1357);
    join_none
    repeat (3) @(negedge clk);
    check("R7 ready low", {31'b0, op_ready}, 32'h0);
    check("R7 held word", decision, 32'h00000042);
    check("R7 held valid", {31'b0, res_valid}, 32'h1);
    // R5 selector on a fault result
    #1; hit = 1'b1; cached = 32'hAAAA5555; computed = 32'h12121212;
    @(negedge clk);
    check("R5 fault picks decision", final_p, 32'h00000042);
    @(posedge clk); #1 res_ready = 1'b1;
    @(posedge clk); #1 res_ready = 1'b0;
    wait fork;
    @(negedge clk);
    check("R6 second result kept", {31'b0, res_valid}, 32'h1);
    check("R7 second word", decision, 32'h24681357);
    check("R5 hit picks cache", final_p, 32'hAAAA5555);
    #1 hit = 1'b0;
    @(negedge clk);
    check("R5 miss picks product", final_p, 32'h12121212);
    @(posedge clk); #1 res_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 queue drained", exp_q.size(), 32'h0);

    // R8 reset clears a loaded result
    res_ready = 1'b0;
    send(16'hAAAA, 16'h0001);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0; res_ready = 1'b1;
    void'(exp_q.pop_back());
    @(negedge clk);
    check("R8 valid cleared", {31'b0, res_valid}, 32'h0);
    check("R8 decision cleared", decision, 32'h0);

    summary();
    $finish;
  end
endmodule